// File: doc/BRIEF.md
# Power-On Initialization Sequencer

This block brings a sensor core out of power-on. It keeps the core in reset until three supply-good inputs are all high in the same cycle. It then runs a two-phase startup. In the first phase, the fuse array is powered and copied word by word into mirror registers over a request/acknowledge handshake. Fuse power is removed as soon as the last word is acknowledged. The serial interface stays disabled for the whole first phase. In the second phase, the serial interface is enabled for register traffic while a voltage reference settles. When the high-pass filter select input is set, the filter is also initialized during this phase, which makes the phase much longer. Acceleration data is enabled only after the second phase ends. A busy status bit covers everything from reset until then.

Phase lengths are given in microseconds and converted to cycle counts from a clock-frequency parameter, so a bench can run a shortened sequence. The controller has five states:
- `ST_HOLD`: reset held.
- `ST_P1_FETCH`: fuse copy in progress, fuse powered.
- `ST_P1_DRAIN`: copy done, fuse unpowered, waiting for the phase-one time to elapse.
- `ST_P2_SETTLE`: reference settling and optional filter init.
- `ST_READY`.

The transitions are:
- `ST_HOLD` to `ST_P1_FETCH` when all supplies are good.
- `ST_P1_FETCH` to `ST_P1_DRAIN` on the acknowledge of the last word.
- `ST_P1_DRAIN` to `ST_P2_SETTLE` when the phase-one count has elapsed.
- `ST_P2_SETTLE` to `ST_READY` when the selected phase-two count has elapsed.
- Any state to `ST_HOLD` when any supply-good input is low.
- Any state to `ST_HOLD` on the asynchronous reset.

Top module: `pwr_init_seq`

## Requirements
- R1: While any bit of `supply_ok` is low, the next cycle shows `core_rst_n`, `fuse_pwr_en`, `fuse_req`, `spi_en`, `accel_en` and `hpf_init` all low and `init_busy` high. Supplies that are only partly good never start the sequence.
- R2: The cycle after all three supplies are first seen high, phase one begins. In phase one `core_rst_n` and `fuse_pwr_en` are high and `spi_en` is low.
- R3: During phase one `fuse_req` is high and `fuse_addr` steps 0, 1, … FUSE_WORDS-1, advancing only after a `fuse_ack`. Word i (from `fuse_rdata` at its acknowledge) lands in `mirror_data[i*FUSE_W +: FUSE_W]`.
- R4: `fuse_pwr_en` falls on the clock edge that accepts the acknowledge of the last word. It stays low until the sequence restarts.
- R5: If the fuse copy finishes in time, `spi_en` rises exactly P1 cycles after phase one begins, where P1 = PH1_US × CLK_HZ / 1e6. Otherwise it rises one cycle after `fuse_pwr_en` falls.
- R6: In phase two `spi_en` and `init_busy` are high and `accel_en` is low. The phase lasts PH2_SHORT_US worth of cycles when `hpf_sel` is 0 and PH2_LONG_US worth when it is 1. `hpf_init` is high throughout phase two exactly when `hpf_sel` is 1.
- R7: After phase two, `accel_en` and `spi_en` are high, and `init_busy` and `hpf_init` are low.
- R8: A supply drop in any phase returns the block to reset on the next edge. When the supplies recover, the whole sequence restarts from fuse word 0 with full phase lengths.
- R9: Asserting `rst_n` low clears the enables at once and sets `init_busy`. After release, the sequence restarts from the beginning.
- R10: `hpf_sel` is sampled when phase two begins. Changing it during phase two does not alter that phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 3 | Supply-good indications, all must be high |
| hpf_sel | input | 1 | High-pass filter select configuration bit |
| fuse_ack | input | 1 | Fuse word read acknowledge |
| fuse_rdata | input | FUSE_W | Fuse word data, valid with `fuse_ack` |
| fuse_req | output | 1 | Fuse word read request |
| fuse_addr | output | FUSE_AW | Fuse word address |
| fuse_pwr_en | output | 1 | Fuse array power enable |
| mirror_data | output | FUSE_WORDS*FUSE_W | Mirror registers, word i at bits i*FUSE_W |
| core_rst_n | output | 1 | Internal reset to the core, active low |
| spi_en | output | 1 | Serial interface register access enable |
| accel_en | output | 1 | Acceleration result enable |
| hpf_init | output | 1 | High-pass filter initialization active |
| init_busy | output | 1 | Initialization in progress status |

## Verification
All outputs decode the registered state. A supply drop is therefore visible one edge after it is sampled, while `rst_n` acts with no edge at all. Phase one starts on the edge that first sees all supplies good, so `spi_en` appears P1 edges later and `accel_en` a further P2 edges later. The bench counts edges from the moment it raises the supplies and compares against those sums, sampling on the falling clock edge.

With a slow fuse model, the bench instead expects `spi_en` exactly one edge after `fuse_pwr_en` falls. Mirror contents and the address order are compared against an arithmetic pattern derived from each run's seed.

// File: rtl/pis_pkg.sv
package pis_pkg;

    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_P1_FETCH  = 3'd1,
        ST_P1_DRAIN  = 3'd2,
        ST_P2_SETTLE = 3'd3,
        ST_READY     = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic core_rst_n;
        logic fuse_pwr_en;
        logic fuse_req;
        logic spi_en;
        logic accel_en;
        logic hpf_init;
        logic init_busy;
    } seq_out_t;

endpackage

// File: rtl/pis_timer.sv
module pis_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Free-running elapsed-cycle counter; saturates so a late exit never wraps.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pis_fuse_copy.sv
module pis_fuse_copy #(
    parameter int FUSE_WORDS = 4,
    parameter int FUSE_W     = 8,
    localparam int AW        = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    input  logic                         fetch,
    input  logic                         ack,
    input  logic [FUSE_W-1:0]            rdata,
    output logic [AW-1:0]                addr,
    output logic                         last,
    output logic [FUSE_WORDS*FUSE_W-1:0] mirror
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(FUSE_WORDS - 1);

    assign last = (addr == LAST_ADDR);

    // Word pointer: back to 0 on restart, advances per accepted word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (restart) begin
            addr <= '0;
        end else if (fetch && ack && !last) begin
            addr <= addr + 1'b1;
        end
    end

    // One mirror register per fuse word.
    for (genvar i = 0; i < FUSE_WORDS; i++) begin : g_mirror
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mirror[i*FUSE_W +: FUSE_W] <= '0;
            end else if (fetch && ack && (addr == AW'(i))) begin
                mirror[i*FUSE_W +: FUSE_W] <= rdata;
            end
        end
    end

endmodule

// File: rtl/pwr_init_seq.sv
module pwr_init_seq
    import pis_pkg::*;
#(
    parameter int  CLK_HZ       = 40_000_000,
    parameter int  PH1_US       = 800,
    parameter int  PH2_SHORT_US = 3_000,
    parameter int  PH2_LONG_US  = 200_000,
    parameter int  FUSE_WORDS   = 4,
    parameter int  FUSE_W       = 8,
    localparam int FUSE_AW      = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   supply_ok,
    input  logic                         hpf_sel,
    input  logic                         fuse_ack,
    input  logic [FUSE_W-1:0]            fuse_rdata,
    output logic                         fuse_req,
    output logic [FUSE_AW-1:0]           fuse_addr,
    output logic                         fuse_pwr_en,
    output logic [FUSE_WORDS*FUSE_W-1:0] mirror_data,
    output logic                         core_rst_n,
    output logic                         spi_en,
    output logic                         accel_en,
    output logic                         hpf_init,
    output logic                         init_busy
);

    localparam longint CYC_PER_US = longint'(CLK_HZ) / 64'd1_000_000;
    localparam longint P1_CYC     = CYC_PER_US * PH1_US;
    localparam longint P2S_CYC    = CYC_PER_US * PH2_SHORT_US;
    localparam longint P2L_CYC    = CYC_PER_US * PH2_LONG_US;
    localparam longint MAX_CYC    = (P2L_CYC > P2S_CYC)
                                    ? ((P2L_CYC > P1_CYC) ? P2L_CYC : P1_CYC)
                                    : ((P2S_CYC > P1_CYC) ? P2S_CYC : P1_CYC);
    localparam int     CNT_W      = $clog2(MAX_CYC + 1) + 1;

    localparam logic [CNT_W-1:0] P1_END  = CNT_W'(P1_CYC - 1);
    localparam logic [CNT_W-1:0] P2S_END = CNT_W'(P2S_CYC - 1);
    localparam logic [CNT_W-1:0] P2L_END = CNT_W'(P2L_CYC - 1);

    seq_state_t       state_q, state_d;
    seq_out_t         outs;
    logic             all_ok;
    logic             hpf_q;
    logic             p1_done;
    logic             p2_done;
    logic             timer_clr;
    logic             fuse_last;
    logic [CNT_W-1:0] elapsed;

    assign all_ok    = &supply_ok;
    assign p1_done   = (elapsed >= P1_END);
    assign p2_done   = (elapsed >= (hpf_q ? P2L_END : P2S_END));
    // Restart the count when a timed phase is about to begin.
    assign timer_clr = (state_q == ST_HOLD) ||
                       ((state_q == ST_P1_DRAIN) && p1_done);

    pis_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .cnt   (elapsed)
    );

    pis_fuse_copy #(
        .FUSE_WORDS (FUSE_WORDS),
        .FUSE_W     (FUSE_W)
    ) u_fuse (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_HOLD),
        .fetch   (state_q == ST_P1_FETCH),
        .ack     (fuse_ack),
        .rdata   (fuse_rdata),
        .addr    (fuse_addr),
        .last    (fuse_last),
        .mirror  (mirror_data)
    );

    // Next-state logic; a supply drop overrides every transition.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:      if (all_ok)                state_d = ST_P1_FETCH;
            ST_P1_FETCH:  if (fuse_ack && fuse_last) state_d = ST_P1_DRAIN;
            ST_P1_DRAIN:  if (p1_done)               state_d = ST_P2_SETTLE;
            ST_P2_SETTLE: if (p2_done)               state_d = ST_READY;
            ST_READY:                                state_d = ST_READY;
            default:                                 state_d = ST_HOLD;
        endcase
        if (!all_ok) begin
            state_d = ST_HOLD;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Filter select captured as phase two starts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpf_q <= 1'b0;
        end else if ((state_q == ST_P1_DRAIN) && p1_done) begin
            hpf_q <= hpf_sel;
        end
    end

    // Output decode.
    always_comb begin
        outs = '{core_rst_n: 1'b0, fuse_pwr_en: 1'b0, fuse_req: 1'b0,
                 spi_en: 1'b0, accel_en: 1'b0, hpf_init: 1'b0,
                 init_busy: 1'b1};
        unique case (state_q)
            ST_HOLD: begin
            end
            ST_P1_FETCH: begin
                outs.core_rst_n  = 1'b1;
                outs.fuse_pwr_en = 1'b1;
                outs.fuse_req    = 1'b1;
            end
            ST_P1_DRAIN: begin
                outs.core_rst_n  = 1'b1;
            end
            ST_P2_SETTLE: begin
                outs.core_rst_n  = 1'b1;
                outs.spi_en      = 1'b1;
                outs.hpf_init    = hpf_q;
            end
            ST_READY: begin
                outs.core_rst_n  = 1'b1;
                outs.spi_en      = 1'b1;
                outs.accel_en    = 1'b1;
                outs.init_busy   = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign core_rst_n  = outs.core_rst_n;
    assign fuse_pwr_en = outs.fuse_pwr_en;
    assign fuse_req    = outs.fuse_req;
    assign spi_en      = outs.spi_en;
    assign accel_en    = outs.accel_en;
    assign hpf_init    = outs.hpf_init;
    assign init_busy   = outs.init_busy;

endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    supply_ok,
    input logic          fuse_req,
    input logic          fuse_ack,
    input logic [AW-1:0] fuse_addr,
    input logic          fuse_pwr_en,
    input logic          core_rst_n,
    input logic          spi_en,
    input logic          accel_en,
    input logic          hpf_init,
    input logic          init_busy
);

    // R1
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&supply_ok) |=> (!core_rst_n && !fuse_pwr_en && !spi_en && !accel_en && init_busy));

    // R2
    p1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_pwr_en |-> (!spi_en && core_rst_n));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_req && $past(fuse_req) && (fuse_addr != $past(fuse_addr))) |-> $past(fuse_ack));

    // R3
    req_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req |-> fuse_pwr_en);

    // R4
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fuse_pwr_en) && core_rst_n) |-> $past(fuse_ack));

    // R5
    spi_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_en) |-> (!fuse_pwr_en && !$past(fuse_pwr_en)));

    // R6
    hpf_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hpf_init |-> (spi_en && !accel_en && init_busy));

    // R7
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accel_en |-> (spi_en && !init_busy && !hpf_init));

endmodule

bind pwr_init_seq pis_checker #(.AW(FUSE_AW)) u_pis_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .fuse_req    (fuse_req),
    .fuse_ack    (fuse_ack),
    .fuse_addr   (fuse_addr),
    .fuse_pwr_en (fuse_pwr_en),
    .core_rst_n  (core_rst_n),
    .spi_en      (spi_en),
    .accel_en    (accel_en),
    .hpf_init    (hpf_init),
    .init_busy   (init_busy)
);

// File: tb/pwr_init_seq_bench.sv
module pwr_init_seq_bench;

    localparam int CLK_HZ = 1_000_000;
    localparam int PH1    = 20;
    localparam int PH2S   = 30;
    localparam int PH2L   = 60;
    localparam int WORDS  = 4;
    localparam int FW     = 8;
    localparam int AW     = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0]          supply_ok = 3'b000;
    logic                hpf_sel = 1'b0;
    logic                fuse_ack = 1'b0;
    logic [FW-1:0]       fuse_rdata = '0;
    logic                fuse_req;
    logic [AW-1:0]       fuse_addr;
    logic                fuse_pwr_en;
    logic [WORDS*FW-1:0] mirror_data;
    logic                core_rst_n;
    logic                spi_en;
    logic                accel_en;
    logic                hpf_init;
    logic                init_busy;

    int tests = 0;
    int fails = 0;
    int ack_dly = 1;
    int seed = 0;
    int wcnt = 0;
    int exp_idx = 0;
    int addr_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_init_seq #(
        .CLK_HZ(CLK_HZ), .PH1_US(PH1), .PH2_SHORT_US(PH2S), .PH2_LONG_US(PH2L),
        .FUSE_WORDS(WORDS), .FUSE_W(FW)
    ) u_pwr_init_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hpf_sel(hpf_sel),
        .fuse_ack(fuse_ack), .fuse_rdata(fuse_rdata), .fuse_req(fuse_req),
        .fuse_addr(fuse_addr), .fuse_pwr_en(fuse_pwr_en), .mirror_data(mirror_data),
        .core_rst_n(core_rst_n), .spi_en(spi_en), .accel_en(accel_en),
        .hpf_init(hpf_init), .init_busy(init_busy)
    );

    function automatic logic [FW-1:0] pat(int a, int s);
        return FW'((a * 29 + s * 13 + 5) ^ (s << 2));
    endfunction

    // Fuse array model: acknowledges each request after ack_dly cycles.
    always @(posedge clk) begin
        if (!core_rst_n) begin
            fuse_ack <= 1'b0;
            wcnt     <= 0;
            exp_idx  <= 0;
        end else if (fuse_req && !fuse_ack) begin
            if (wcnt + 1 >= ack_dly) begin
                fuse_ack   <= 1'b1;
                fuse_rdata <= pat(int'(fuse_addr), seed);
                wcnt       <= 0;
                if (int'(fuse_addr) != exp_idx) addr_err <= addr_err + 1;
                exp_idx    <= exp_idx + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            fuse_ack <= 1'b0;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_cleared(string req);
        check({req, " core_rst_n"}, int'(core_rst_n), 0);
        check({req, " enables"}, int'({fuse_pwr_en, fuse_req, spi_en, accel_en, hpf_init}), 0);
        check({req, " init_busy"}, int'(init_busy), 1);
    endtask

    // Full startup; slow selects a fuse model slower than phase one.
    task automatic run_seq(bit hpf, bit slow, bit toggle, int s);
        int k = 0;
        int kspi = -1;
        int kacc = -1;
        int kpoff = -1;
        int bad_p1 = 0;
        int pwr_back = 0;
        int hpf_bad = 0;
        int exp_p2;
        hpf_sel   = hpf;
        ack_dly   = slow ? 8 : 1;
        seed      = s;
        addr_err  = 0;
        supply_ok = 3'b111;
        while (kacc < 0 && k < 500) begin
            tick();
            k++;
            if (k == 1) begin
                // R2: phase one visible one edge after supplies good
                check("R2 phase one entry", int'({core_rst_n, fuse_pwr_en, spi_en}), 3'b110);
            end
            if (fuse_pwr_en && spi_en) bad_p1++;
            if (kpoff >= 0 && fuse_pwr_en) pwr_back++;
            if (kpoff < 0 && k > 1 && !fuse_pwr_en) kpoff = k;
            if (kspi < 0 && spi_en) begin
                kspi = k;
                if (toggle) hpf_sel = ~hpf_sel;
            end
            if (kspi >= 0 && !accel_en && hpf_init != hpf) hpf_bad++;
            if (accel_en) kacc = k;
        end
        exp_p2 = hpf ? PH2L : PH2S;
        check("R2 spi_en low in phase one", bad_p1, 0);
        check("R4 fuse power stays off", pwr_back, 0);
        if (slow) begin
            // R5: slow copy, spi one edge after fuse power off
            check("R5 slow phase one end", kspi, kpoff + 1);
        end else begin
            // R5: phase one lasts P1 edges
            check("R5 phase one length", kspi, PH1 + 1);
            check("R4 fuse off before phase end", int'(kpoff < kspi), 1);
        end
        // R6 / R10: phase two length from sampled select
        check(toggle ? "R10 phase two length after toggle" : "R6 phase two length",
              kacc - kspi, exp_p2);
        check("R6 hpf_init in phase two", hpf_bad, 0);
        // R7
        check("R7 ready outputs", int'({accel_en, spi_en, init_busy, hpf_init}), 4'b1100);
        check("R3 fuse address order", addr_err, 0);
        for (int i = 0; i < WORDS; i++) begin
            check("R3 mirror word", int'(mirror_data[i*FW +: FW]), int'(pat(i, s)));
        end
    endtask

    // Drop one supply bit in phase one (p2 = 0) or phase two (p2 = 1).
    task automatic run_drop(bit p2, int bit_idx);
        int k = 0;
        ack_dly   = 1;
        supply_ok = 3'b111;
        if (p2) begin
            while (!spi_en && k < 200) begin tick(); k++; end
            tick();
        end else begin
            tick(); tick(); tick();
        end
        supply_ok[bit_idx] = 1'b0;
        tick();
        // R8: back in reset one edge after the drop
        check_cleared(p2 ? "R8 drop in phase two" : "R8 drop in phase one");
        tick();
        supply_ok = 3'b000;
        tick();
    endtask

    initial begin
        #(10 * 200_000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        supply_ok = 3'b111;
        #23;
        // R9: reset state
        check_cleared("R9 reset state");
        supply_ok = 3'b000;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every partial supply combination holds reset
        for (int c = 0; c < 7; c++) begin
            supply_ok = 3'(c);
            tick(); tick(); tick();
            check_cleared("R1 partial supplies");
        end
        supply_ok = 3'b000;
        tick();
        run_seq(1'b0, 1'b0, 1'b0, 3);
        supply_ok = 3'b000; tick(); tick();
        run_seq(1'b1, 1'b0, 1'b0, 11);
        supply_ok = 3'b000; tick(); tick();
        run_seq(1'b0, 1'b1, 1'b0, 7);
        supply_ok = 3'b000; tick(); tick();
        run_seq(1'b0, 1'b0, 1'b1, 19);
        supply_ok = 3'b000; tick(); tick();
        run_seq(1'b1, 1'b0, 1'b1, 23);
        supply_ok = 3'b000; tick(); tick();
        for (int b = 0; b < 3; b++) begin
            run_drop(1'b0, b);
            run_drop(1'b1, b);
        end
        // R8: restart after a drop gives a full sequence
        run_seq(1'b1, 1'b1, 1'b0, 31);
        // R9: asynchronous reset in ready state clears at once
        #2;
        rst_n = 1'b0;
        #1;
        check_cleared("R9 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        supply_ok = 3'b000;
        tick();
        // R9: sequence restarts after reset
        run_seq(1'b0, 1'b0, 1'b0, 41);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule